// File: doc/BRIEF.md
# Strap-Latched Clock Configuration Controller

This controller keeps the configuration state for a bank of clock outputs: eight programmable clocks with a 2-bit rate code each, a CPU-rate select bit, a 2-bit code for an auxiliary clock, and one enable per output. The divider logic downstream reads its codes and enables. The controller makes no clocks of its own.

Some package pins are shared between configuration and clocking. While power-on reset runs, they are inputs. A cycle counter measures the reset window, and in its last cycle the controller samples the pins into a 5-bit latch. One cycle after the capture, it turns the pins into outputs. The latched bits give the CPU-rate select and the auxiliary code.

A mode input chooses where the codes come from. In pin mode the rate codes come from dedicated select pins and from the latch. In register mode they come from register values supplied by the serial-bus side. An enable change reaches an output only while that output's clock is low.

Top module: `clkcfg_strap_ctrl`

## Requirements
- R1: While `rst_n` is low, the following values hold. Every `out_en` bit is 1 and `strap_oe` is all zeros. `cpu_sel` is 1 (100 MHz) and `aux_code` is 00. Every `pci_code` field is 00.
- R2: The reset-done counter counts rising clock edges after reset is released. At the POR_CYCLES-th edge, `strap_latched` takes the value of `strap_in`. Before that edge it shows 00001, and `strap_in` at any other time leaves it unchanged.
- R3: `strap_oe` becomes all ones one edge after the capture edge, so it never changes before the latch holds its value. It then stays all ones until the next reset.
- R4: In pin mode (`sw_mode` = 0), `pci_code[2i+1:2i]` equals {`pin_sel_b[i]`, `pin_sel_a[i]`} one edge after the pins are applied. Codes 00, 01, 10 and 11 select 25, 33.33, 50 and 66.66 MHz. A new code appears whole in a single step.
- R5: In pin mode, `cpu_sel` equals latch bit 0 (0 = 125 MHz, 1 = 100 MHz) and `aux_code` equals latch bits [2:1]. Before capture they are therefore 1 and 00.
- R6: In register mode (`sw_mode` = 1), the outputs follow the register inputs one edge later. `pci_code` follows `reg_pci_code`, `cpu_sel` follows `reg_cpu_sel` and `aux_code` follows `reg_aux_code`. The select pins and the latch have no effect.
- R7: Output k's enable request is bit k of {`reg_fix_en`, `reg_pci_en`}. `out_en[k]` takes that request on an edge only while `clk_lvl[k]` is 0, and holds its value while `clk_lvl[k]` is 1.
- R8: `aux_code` 11 means the auxiliary clock is off: its enable request is forced to 0 whatever its enable bit says. Other codes mean 83.33, 71.42 and 66.66 MHz for 00, 01 and 10. The auxiliary clock is output NUM_PCI+AUX_IDX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_in | input | STRAP_W | Levels on the shared pins while they are inputs |
| strap_oe | output | STRAP_W | Shared-pin output enables, 1 = drive clock |
| strap_latched | output | STRAP_W | Latched strap value ([0] CPU select, [2:1] aux code) |
| sw_mode | input | 1 | Code source: 0 = pins/latch, 1 = registers |
| pin_sel_a | input | NUM_PCI | Low select bit per programmable clock |
| pin_sel_b | input | NUM_PCI | High select bit per programmable clock |
| reg_pci_code | input | 2*NUM_PCI | Register codes, field i at [2i+1:2i] |
| reg_cpu_sel | input | 1 | Register CPU-rate select |
| reg_aux_code | input | 2 | Register auxiliary-clock code |
| reg_pci_en | input | NUM_PCI | Enable bits of the programmable clocks |
| reg_fix_en | input | NUM_FIX | Enable bits of the fixed clocks |
| clk_lvl | input | NUM_PCI+NUM_FIX | Present level of each output clock |
| pci_code | output | 2*NUM_PCI | Rate code per programmable clock |
| cpu_sel | output | 1 | CPU-rate select, 1 = 100 MHz |
| aux_code | output | 2 | Auxiliary-clock code |
| out_en | output | NUM_PCI+NUM_FIX | Glitch-safe enable per output |

## Verification
Strap values are held only in the capture cycle, with different garbage before and after it. A latch that tracks the pins, or captures one cycle off, therefore shows a wrong value. Random mixes of mode, select pins and register codes show whether the selected source reaches the outputs and whether the other source leaks through. Random clock levels with random enable requests separate updates in the low phase from updates in the high phase. A directed auxiliary code of 11 with its enable bit set shows whether the off code overrides the enable.

// File: rtl/clkcfg_pkg.sv
// Shared types and reset values of the clock configuration controller.
package clkcfg_pkg;
    typedef logic [1:0] code_t;
    localparam code_t AUX_OFF_CODE = 2'b11;   // auxiliary clock stopped
    localparam code_t AUX_RST_CODE = 2'b00;   // 83.33 MHz
    localparam code_t PCI_RST_CODE = 2'b00;   // 25 MHz
    localparam logic  CPU_RST_SEL  = 1'b1;    // 100 MHz
endpackage

// File: rtl/clkcfg_strap_latch.sv
// Reset-window timer, strap latch and shared-pin direction control.
// Assumes strap_in is stable in the last cycle of the reset window and
// that POR_CYCLES >= 1. Bit 0 of the latch resets to the CPU default.
module clkcfg_strap_latch
    import clkcfg_pkg::*;
#(
    parameter int STRAP_W    = 5,
    parameter int POR_CYCLES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic               captured,
    output logic [STRAP_W-1:0] pin_oe
);
    localparam int CNT_W = $clog2(POR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(POR_CYCLES - 1);
    localparam logic [STRAP_W-1:0] STRAP_RST = {{(STRAP_W-1){1'b0}}, CPU_RST_SEL};

    logic [CNT_W-1:0] por_cnt;

    // Count cycles since reset release until the latch is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)         por_cnt <= '0;
        else if (!captured) por_cnt <= por_cnt + 1'b1;
    end

    // Sample the shared pins once, in the last cycle of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q  <= STRAP_RST;
            captured <= 1'b0;
        end else if (!captured && por_cnt == LAST_CNT) begin
            strap_q  <= strap_in;
            captured <= 1'b1;
        end
    end

    // Turn the shared pins into outputs one cycle after capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        pin_oe <= '0;
        else if (captured) pin_oe <= '1;
    end

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && $past(captured)) |-> $stable(strap_q)); // R2
    AST_OE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_oe) |-> $past(captured)); // R3
    AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&pin_oe) |-> (&pin_oe)); // R3
endmodule

// File: rtl/clkcfg_src_mux.sv
// Chooses pin/latch or register sources for all rate codes and registers
// them, so each change is a single step. Assumes the pin inputs are
// already synchronised to clk.
module clkcfg_src_mux
    import clkcfg_pkg::*;
#(
    parameter int NUM_PCI = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_mode,
    input  logic [NUM_PCI-1:0]   pin_sel_a,
    input  logic [NUM_PCI-1:0]   pin_sel_b,
    input  logic [2*NUM_PCI-1:0] reg_pci_code,
    input  logic                 strap_cpu,
    input  code_t                strap_aux,
    input  logic                 reg_cpu_sel,
    input  code_t                reg_aux_code,
    output logic [2*NUM_PCI-1:0] pci_code_q,
    output logic                 cpu_sel_q,
    output code_t                aux_code_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_PCI; g++) begin : g_pci
            code_t pin_code;
            assign pin_code = {pin_sel_b[g], pin_sel_a[g]};
            // Register the selected 2-bit code of one programmable clock.
            always_ff @(posedge clk) begin
                if (!rst_n)       pci_code_q[2*g +: 2] <= PCI_RST_CODE;
                else if (sw_mode) pci_code_q[2*g +: 2] <= reg_pci_code[2*g +: 2];
                else              pci_code_q[2*g +: 2] <= pin_code;
            end
        end
    endgenerate

    // Register the CPU select and auxiliary code from the active source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_sel_q  <= CPU_RST_SEL;
            aux_code_q <= AUX_RST_CODE;
        end else if (sw_mode) begin
            cpu_sel_q  <= reg_cpu_sel;
            aux_code_q <= reg_aux_code;
        end else begin
            cpu_sel_q  <= strap_cpu;
            aux_code_q <= strap_aux;
        end
    end
endmodule

// File: rtl/clkcfg_en_gate.sv
// Per-output enable flops that take a new request only while that output's
// clock is low, so the divider never sees an enable edge mid-pulse.
// Assumes clk_lvl is synchronous to clk.
module clkcfg_en_gate #(
    parameter int NUM_OUT = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] clk_lvl,
    input  logic [NUM_OUT-1:0] en_req,
    output logic [NUM_OUT-1:0] en_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_OUT; g++) begin : g_en
            // Update one enable in the output's low phase, hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n)          en_q[g] <= 1'b1;
                else if (!clk_lvl[g]) en_q[g] <= en_req[g];
            end

            AST_EN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(en_q[g]) |-> !$past(clk_lvl[g])); // R7
        end
    endgenerate
endmodule

// File: rtl/clkcfg_strap_ctrl.sv
// Top of the clock configuration controller: strap latch, source mux and
// glitch-safe enables. Output order in clk_lvl/out_en: programmable clocks
// 0..NUM_PCI-1, then fixed clocks; the auxiliary clock is fixed AUX_IDX.
// Strap layout: [0] CPU select, [2:1] auxiliary code, rest latched only.
module clkcfg_strap_ctrl
    import clkcfg_pkg::*;
#(
    parameter int NUM_PCI    = 8,
    parameter int NUM_FIX    = 6,
    parameter int AUX_IDX    = 1,
    parameter int STRAP_W    = 5,
    parameter int POR_CYCLES = 1024,
    localparam int NUM_OUT   = NUM_PCI + NUM_FIX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STRAP_W-1:0]   strap_in,
    output logic [STRAP_W-1:0]   strap_oe,
    output logic [STRAP_W-1:0]   strap_latched,
    input  logic                 sw_mode,
    input  logic [NUM_PCI-1:0]   pin_sel_a,
    input  logic [NUM_PCI-1:0]   pin_sel_b,
    input  logic [2*NUM_PCI-1:0] reg_pci_code,
    input  logic                 reg_cpu_sel,
    input  logic [1:0]           reg_aux_code,
    input  logic [NUM_PCI-1:0]   reg_pci_en,
    input  logic [NUM_FIX-1:0]   reg_fix_en,
    input  logic [NUM_OUT-1:0]   clk_lvl,
    output logic [2*NUM_PCI-1:0] pci_code,
    output logic                 cpu_sel,
    output logic [1:0]           aux_code,
    output logic [NUM_OUT-1:0]   out_en
);
    localparam int AUX_POS = NUM_PCI + AUX_IDX;

    logic               captured;
    logic [STRAP_W-1:0] strap_q;
    logic [NUM_FIX-1:0] fix_req;
    logic [NUM_OUT-1:0] en_req;

    clkcfg_strap_latch #(.STRAP_W(STRAP_W), .POR_CYCLES(POR_CYCLES)) i_latch (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .strap_q(strap_q), .captured(captured), .pin_oe(strap_oe)
    );

    clkcfg_src_mux #(.NUM_PCI(NUM_PCI)) i_mux (
        .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode),
        .pin_sel_a(pin_sel_a), .pin_sel_b(pin_sel_b),
        .reg_pci_code(reg_pci_code),
        .strap_cpu(strap_q[0]), .strap_aux(strap_q[2:1]),
        .reg_cpu_sel(reg_cpu_sel), .reg_aux_code(reg_aux_code),
        .pci_code_q(pci_code), .cpu_sel_q(cpu_sel), .aux_code_q(aux_code)
    );

    // Build enable requests; the off code masks the auxiliary clock.
    always_comb begin
        fix_req = reg_fix_en;
        if (aux_code == AUX_OFF_CODE) fix_req[AUX_IDX] = 1'b0;
        en_req = {fix_req, reg_pci_en};
    end

    clkcfg_en_gate #(.NUM_OUT(NUM_OUT)) i_en (
        .clk(clk), .rst_n(rst_n), .clk_lvl(clk_lvl),
        .en_req(en_req), .en_q(out_en)
    );

    assign strap_latched = strap_q;

    AST_AUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_code == AUX_OFF_CODE && !clk_lvl[AUX_POS]) |=> !out_en[AUX_POS]); // R8
endmodule

// File: tb/test_clkcfg_strap_ctrl.sv
`timescale 1ns/1ps
module test_clkcfg_strap_ctrl;
    localparam int NP = 8, NF = 6, AUXI = 1, SW = 5, POR = 6;
    localparam int NO = NP + NF, AUXP = NP + AUXI;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [SW-1:0] strap_in = '0, strap_oe, strap_latched;
    logic sw_mode = 1'b0, reg_cpu_sel = 1'b0, cpu_sel;
    logic [NP-1:0] pin_sel_a = '0, pin_sel_b = '0, reg_pci_en = '1;
    logic [2*NP-1:0] reg_pci_code = '0, pci_code;
    logic [1:0] reg_aux_code = '0, aux_code;
    logic [NF-1:0] reg_fix_en = '1;
    logic [NO-1:0] clk_lvl = '1, out_en;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    clkcfg_strap_ctrl #(.NUM_PCI(NP), .NUM_FIX(NF), .AUX_IDX(AUXI),
        .STRAP_W(SW), .POR_CYCLES(POR)) i_clkcfg_strap_ctrl (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_oe(strap_oe),
        .strap_latched(strap_latched), .sw_mode(sw_mode),
        .pin_sel_a(pin_sel_a), .pin_sel_b(pin_sel_b),
        .reg_pci_code(reg_pci_code), .reg_cpu_sel(reg_cpu_sel),
        .reg_aux_code(reg_aux_code), .reg_pci_en(reg_pci_en),
        .reg_fix_en(reg_fix_en), .clk_lvl(clk_lvl), .pci_code(pci_code),
        .cpu_sel(cpu_sel), .aux_code(aux_code), .out_en(out_en));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [2*NP-1:0] pin_codes(input logic [NP-1:0] a, input logic [NP-1:0] b);
        logic [2*NP-1:0] r;
        for (int i = 0; i < NP; i++) r[2*i +: 2] = {b[i], a[i]};
        return r;
    endfunction

    function automatic logic [NO-1:0] next_en(input logic [NO-1:0] cur, input logic [NO-1:0] lvl,
                                              input logic [NO-1:0] req_bits, input logic [1:0] aux_now);
        logic [NO-1:0] r;
        for (int k = 0; k < NO; k++) begin
            logic req;
            req = req_bits[k] && !(k == AUXP && aux_now == 2'b11);
            r[k] = lvl[k] ? cur[k] : req;
        end
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [SW-1:0] lv;
        logic [NO-1:0] exp_en;
        logic [1:0] aux_prev;
        void'($urandom(32'd20240611));
        lv = 5'b10100;               // cpu 0 (125 MHz), aux 10
        pin_sel_a = 8'hA5; pin_sel_b = 8'h3C;
        strap_in = 5'b01011;
        repeat (3) step();
        // R1: values during reset
        chk("R1 out_en", 32'(out_en), 32'((1 << NO) - 1));
        chk("R1 strap_oe", 32'(strap_oe), 32'h0);
        chk("R1 cpu_sel", 32'(cpu_sel), 32'h1);
        chk("R1 aux_code", 32'(aux_code), 32'h0);
        chk("R1 pci_code", 32'(pci_code), 32'h0);

        rst_n = 1'b1;
        strap_in = 5'b01011;
        repeat (POR - 1) step();
        // R2 / R5: before capture latch at default, codes at defaults
        chk("R2 pre-capture latch", 32'(strap_latched), 32'h1);
        chk("R5 default cpu_sel", 32'(cpu_sel), 32'h1);
        chk("R5 default aux_code", 32'(aux_code), 32'h0);
        chk("R4 pin codes", 32'(pci_code), 32'(pin_codes(8'hA5, 8'h3C)));
        chk("R3 oe low before capture", 32'(strap_oe), 32'h0);
        strap_in = lv;
        step();
        chk("R2 capture", 32'(strap_latched), 32'(lv));
        chk("R3 oe after capture edge", 32'(strap_oe), 32'h0);
        strap_in = 5'b01111;
        step();
        chk("R3 oe set", 32'(strap_oe), 32'h1F);
        chk("R2 latch held", 32'(strap_latched), 32'(lv));
        step();
        chk("R5 cpu from latch", 32'(cpu_sel), 32'(lv[0]));
        chk("R5 aux from latch", 32'(aux_code), 32'(lv[2:1]));

        exp_en = '1;
        aux_prev = lv[2:1];
        for (int it = 0; it < 400; it++) begin
            logic [2*NP-1:0] e_pci;
            logic e_cpu;
            logic [1:0] e_aux;
            sw_mode = $urandom_range(0, 1);
            pin_sel_a = $urandom; pin_sel_b = $urandom;
            reg_pci_code = $urandom; reg_cpu_sel = $urandom_range(0, 1);
            reg_aux_code = $urandom_range(0, 3);
            reg_pci_en = $urandom; reg_fix_en = $urandom;
            clk_lvl = $urandom;
            strap_in = $urandom;
            if (sw_mode) begin
                e_pci = reg_pci_code; e_cpu = reg_cpu_sel; e_aux = reg_aux_code;
            end else begin
                e_pci = pin_codes(pin_sel_a, pin_sel_b); e_cpu = lv[0]; e_aux = lv[2:1];
            end
            exp_en = next_en(exp_en, clk_lvl, {reg_fix_en, reg_pci_en}, aux_prev);
            step();
            if (sw_mode) begin
                chk("R6 pci_code", 32'(pci_code), 32'(e_pci));
                chk("R6 cpu/aux", 32'({cpu_sel, aux_code}), 32'({e_cpu, e_aux}));
            end else begin
                chk("R4 pci_code", 32'(pci_code), 32'(e_pci));
                chk("R5 cpu/aux", 32'({cpu_sel, aux_code}), 32'({e_cpu, e_aux}));
            end
            chk("R7 out_en", 32'(out_en), 32'(exp_en));
            chk("R2 latch frozen", 32'(strap_latched), 32'(lv));
            chk("R3 oe stays", 32'(strap_oe), 32'h1F);
            aux_prev = e_aux;
        end

        // R8: aux code 11 overrides a set enable bit
        sw_mode = 1'b1; reg_aux_code = 2'b11; reg_fix_en = '1; reg_pci_en = '1; clk_lvl = '0;
        step(); step();
        chk("R8 aux off", 32'(out_en[AUXP]), 32'h0);
        chk("R7 pci enabled", 32'(out_en[NP-1:0]), 32'hFF);
        // R7: requests held off while clock level is high
        clk_lvl = '1; reg_pci_en = '0;
        step(); step();
        chk("R7 hold in high phase", 32'(out_en[NP-1:0]), 32'hFF);
        clk_lvl = '0;
        step();
        chk("R7 apply in low phase", 32'(out_en[NP-1:0]), 32'h0);
        reg_aux_code = 2'b10;
        step(); step();
        chk("R8 aux back on", 32'(out_en[AUXP]), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule